// File: doc/BRIEF.md
# Vector Unit Trap Level and Length Resolver

This block decides, every cycle, whether the scalable-vector execution unit may be used at the current exception level. If it may not, the block reports which exception level must handle the trap. The decision walks a fixed chain of checks. Two two-bit enable fields come first: one for the vector unit and one for floating point, both taken from the access-control register. The trap bits of the level-2 trap register follow, and the level-3 trap register is checked last. The first check that traps sets the result. A result of zero means access is allowed.

The block also holds three small vector-length control registers, one each for levels 1, 2 and 3, behind a simple register bus. Every bus access returns a response derived from the resolved trap level. From these registers the block computes the effective vector length for the current level. That length is clamped to the smallest setting of every implemented higher level, and it is forced to zero when the vector unit is trapped while floating point is allowed. The floating-point trap level is computed elsewhere and arrives as an input.

Top module: `vtl_resolver`

## Requirements
- R1: After reset, all three length registers hold zero. Every register read returns 0 and `effLen` is 0.
- R2: The vector enable field `vecEnField` traps as follows. Value 0 or 2 traps when `curLvl` is 0 or 1. Value 1 traps only when `curLvl` is 0. Value 3 never traps.
- R3: The floating-point enable field `fpEnField` uses the same encoding as R2. It is checked after the vector field, and a trap from either field settles the result.
- R4: A trap raised by either enable field resolves to `trapLvl` 3 when `secureSt` is 1 and `lvl3Is64` is 0. Otherwise it resolves to `trapLvl` 1.
- R5: Suppose neither field traps, `curLvl` is at most 2, `l2TrapVec` or `l2TrapFp` is set, and `secureSt` is 0. Then `trapLvl` is 2.
- R6: Suppose none of the earlier checks traps. Then `trapLvl` is 3 when `l3VecEn` is 0 or `l3TrapFp` is 1. Otherwise `trapLvl` is 0.
- R7: A bus access to a present register (`busIdx` 1, 2 or 3) returns `busResp` equal to `trapLvl`. The codes are 0 for OK, 1 for an ordinary trap, 2 for a trap to level 2 and 3 for a trap to level 3. A trapped access does not write and reads as 0.
- R8: A write stores only bits [3:0] of `busWdata`. Bits above 3 always read as zero.
- R9: Three `busIdx` cases count as absent: index 0, index 2 when `hasLvl2` is 0, and index 3 when `hasLvl3` is 0. An absent register reads 0, ignores writes and answers `busResp` 0 whatever the trap level.
- R10: The effective length starts from the register of the current level, and level 0 uses register 1. It is then reduced to the minimum with register 2 when `hasLvl2` is 1 and `curLvl` is below 2. Next it is reduced to the minimum with register 3 when `hasLvl3` is 1 and `curLvl` is below 3.
- R11: `effLen` is 0 whenever `trapLvl` is nonzero and `fpTrapLvl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| curLvl | input | 2 | Current exception level |
| secureSt | input | 1 | Core is in secure state |
| hasLvl2 | input | 1 | Level 2 implemented |
| hasLvl3 | input | 1 | Level 3 implemented |
| lvl3Is64 | input | 1 | Level 3 runs in 64-bit state |
| vecEnField | input | 2 | Vector enable field of the access-control register |
| fpEnField | input | 2 | Floating-point enable field of the access-control register |
| l2TrapVec | input | 1 | Level-2 vector trap bit |
| l2TrapFp | input | 1 | Level-2 floating-point trap bit |
| l3VecEn | input | 1 | Level-3 vector enable bit |
| l3TrapFp | input | 1 | Level-3 floating-point trap bit |
| fpTrapLvl | input | 2 | Floating-point trap level, 0 when FP is allowed |
| busSel | input | 1 | Bus access valid |
| busWr | input | 1 | Bus access is a write |
| busIdx | input | 2 | Length register index (1..3) |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Read data |
| busResp | output | 2 | Access response code |
| trapLvl | output | 2 | Resolved trap level, 0 when enabled |
| effLen | output | 4 | Effective vector length |

## Verification
All outputs except stored state are combinational. A wrong priority or a wrong field decode therefore shows on `trapLvl` and `busResp` in the same cycle as the input change. A corrupt length register shows up in two places. It appears on `effLen` in the cycle after the bad write, once a level that uses that register is selected. It also appears on the next read of that index. A write that slips past a trap or an absent index remains invisible until that register is read back, so every blocked write is followed by a read-back.

// File: rtl/vtl_pkg.sv
package vtl_pkg;
  localparam int LVL_W    = 2;
  localparam int NUM_REGS = 3;

  typedef enum logic [LVL_W-1:0] {
    RESP_OK      = 2'd0,
    RESP_TRAP    = 2'd1,
    RESP_TRAP_L2 = 2'd2,
    RESP_TRAP_L3 = 2'd3
  } bus_resp_e;

  // strobes from control to the length datapath
  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [LVL_W-1:0] regIdx;
    logic [LVL_W-1:0] ownIdx;
    logic             clampL2;
    logic             clampL3;
    logic             zeroLen;
    logic [3:1]       present;
  } dp_strobe_t;
endpackage

// File: rtl/vtl_ctrl.sv
module vtl_ctrl
  import vtl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] curLvl,
  input  logic             secureSt,
  input  logic             hasLvl2,
  input  logic             hasLvl3,
  input  logic             lvl3Is64,
  input  logic [1:0]       vecEnField,
  input  logic [1:0]       fpEnField,
  input  logic             l2TrapVec,
  input  logic             l2TrapFp,
  input  logic             l3VecEn,
  input  logic             l3TrapFp,
  input  logic [LVL_W-1:0] fpTrapLvl,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [LVL_W-1:0] busIdx,
  output logic [LVL_W-1:0] trapLvl,
  output logic [LVL_W-1:0] busResp,
  output dp_strobe_t       st
);
  localparam int NUM_FIELDS = 2;

  function automatic logic fieldTraps(input logic [1:0] f, input logic [LVL_W-1:0] lvl);
    case (f)
      2'd1:    return lvl == '0;
      2'd3:    return 1'b0;
      default: return lvl <= LVL_W'(1);
    endcase
  endfunction

  logic [1:0]            enField [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldHit;
  logic                  fieldAny;
  logic [LVL_W-1:0]      fieldTarget;
  logic                  l2Hit, l3Hit;
  logic                  regPresent, accessOk;
  bus_resp_e             respE;

  assign enField[0] = vecEnField;
  assign enField[1] = fpEnField;

  // fields are walked in order: vector first, then floating point
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign fieldHit[g] = fieldTraps(enField[g], curLvl);
  end

  assign fieldAny    = |fieldHit;
  assign fieldTarget = (secureSt && !lvl3Is64) ? LVL_W'(3) : LVL_W'(1);
  assign l2Hit       = (curLvl <= LVL_W'(2)) && (l2TrapVec || l2TrapFp) && !secureSt;
  assign l3Hit       = !l3VecEn || l3TrapFp;

  always_comb begin
    if (fieldAny)   trapLvl = fieldTarget;
    else if (l2Hit) trapLvl = LVL_W'(2);
    else if (l3Hit) trapLvl = LVL_W'(3);
    else            trapLvl = '0;
  end

  always_comb begin
    case (busIdx)
      LVL_W'(1): regPresent = 1'b1;
      LVL_W'(2): regPresent = hasLvl2;
      LVL_W'(3): regPresent = hasLvl3;
      default:   regPresent = 1'b0;
    endcase
  end

  assign respE    = (busSel && regPresent) ? bus_resp_e'(trapLvl) : RESP_OK;
  assign busResp  = respE;
  assign accessOk = busSel && regPresent && (trapLvl == '0);

  always_comb begin
    st         = '0;
    st.wrEn    = accessOk && busWr;
    st.rdEn    = accessOk && !busWr;
    st.regIdx  = busIdx;
    st.ownIdx  = (curLvl <= LVL_W'(1)) ? LVL_W'(1) : curLvl;
    st.clampL2 = hasLvl2 && (curLvl < LVL_W'(2));
    st.clampL3 = hasLvl3 && (curLvl < LVL_W'(3));
    st.zeroLen = (trapLvl != '0) && (fpTrapLvl == '0);
    st.present = {hasLvl3, hasLvl2, 1'b1};
  end

  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && trapLvl != '0 && busIdx == LVL_W'(1)) |-> !st.wrEn);  // R7
  AST_L1_ONLY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (trapLvl == LVL_W'(1)) |-> (curLvl <= LVL_W'(1)));  // R4
  AST_L2_NONSECURE: assert property (@(posedge clk) disable iff (!rstN)
    (trapLvl == LVL_W'(2)) |-> (!secureSt && curLvl != LVL_W'(3)));  // R5
  AST_L3_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (l3VecEn && !l3TrapFp && trapLvl == LVL_W'(3)) |-> (secureSt && !lvl3Is64));  // R6
  AST_ABSENT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busIdx == LVL_W'(2) && !hasLvl2) |-> !st.wrEn);  // R9
endmodule

// File: rtl/vtl_lendp.sv
module vtl_lendp
  import vtl_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        st,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [LEN_W-1:0]  effLen
);
  localparam logic [DATA_W-1:0] LEN_MASK = DATA_W'((1 << LEN_W) - 1);

  logic [LEN_W-1:0] wrVal;
  logic [LEN_W-1:0] view [0:NUM_REGS];
  logic [LEN_W-1:0] base, afterL2, afterL3;

  assign wrVal   = LEN_W'(busWdata & LEN_MASK);
  assign view[0] = '0;

  for (genvar i = 1; i <= NUM_REGS; i++) begin : g_len
    logic [LEN_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (st.wrEn && st.regIdx == LVL_W'(i)) q <= wrVal;
    end
    assign view[i] = st.present[i] ? q : '0;
  end

  assign busRdata = st.rdEn ? DATA_W'(view[st.regIdx]) : '0;

  assign base    = view[st.ownIdx];
  assign afterL2 = (st.clampL2 && view[2] < base)    ? view[2] : base;
  assign afterL3 = (st.clampL3 && view[3] < afterL2) ? view[3] : afterL2;
  assign effLen  = st.zeroLen ? '0 : afterL3;

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:LEN_W] == '0);  // R8
  AST_CLAMP_L2: assert property (@(posedge clk) disable iff (!rstN)
    (st.clampL2 && !st.zeroLen) |-> (effLen <= view[2]));  // R10
  AST_CLAMP_L3: assert property (@(posedge clk) disable iff (!rstN)
    (st.clampL3 && !st.zeroLen) |-> (effLen <= view[3]));  // R10
endmodule

// File: rtl/vtl_resolver.sv
module vtl_resolver
  import vtl_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        curLvl,
  input  logic              secureSt,
  input  logic              hasLvl2,
  input  logic              hasLvl3,
  input  logic              lvl3Is64,
  input  logic [1:0]        vecEnField,
  input  logic [1:0]        fpEnField,
  input  logic              l2TrapVec,
  input  logic              l2TrapFp,
  input  logic              l3VecEn,
  input  logic              l3TrapFp,
  input  logic [1:0]        fpTrapLvl,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busIdx,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        busResp,
  output logic [1:0]        trapLvl,
  output logic [LEN_W-1:0]  effLen
);
  dp_strobe_t st;

  vtl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .curLvl(curLvl), .secureSt(secureSt),
    .hasLvl2(hasLvl2), .hasLvl3(hasLvl3), .lvl3Is64(lvl3Is64),
    .vecEnField(vecEnField), .fpEnField(fpEnField),
    .l2TrapVec(l2TrapVec), .l2TrapFp(l2TrapFp),
    .l3VecEn(l3VecEn), .l3TrapFp(l3TrapFp), .fpTrapLvl(fpTrapLvl),
    .busSel(busSel), .busWr(busWr), .busIdx(busIdx),
    .trapLvl(trapLvl), .busResp(busResp), .st(st)
  );

  vtl_lendp #(.LEN_W(LEN_W), .DATA_W(DATA_W)) lendp_i (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata),
    .busRdata(busRdata), .effLen(effLen)
  );

  AST_ZERO_LEN_ON_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (trapLvl != 2'd0 && fpTrapLvl == 2'd0) |-> (effLen == '0));  // R11
endmodule

// File: tb/vtl_resolver_tb.sv
module vtl_resolver_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] curLvl = 2'd1;
  logic secureSt = 1'b0, hasLvl2 = 1'b1, hasLvl3 = 1'b1, lvl3Is64 = 1'b1;
  logic [1:0] vecEnField = 2'd3, fpEnField = 2'd3;
  logic l2TrapVec = 1'b0, l2TrapFp = 1'b0, l3VecEn = 1'b1, l3TrapFp = 1'b0;
  logic [1:0] fpTrapLvl = 2'd0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busIdx = 2'd0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata;
  logic [1:0] busResp, trapLvl;
  logic [3:0] effLen;

  int totalCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  vtl_resolver dut_i (.*);

  // {cur, secure, lvl3Is64, vecField, fpField, l2Vec, l2Fp, l3En, l3Fp, expected}
  localparam logic [13:0] TV [20] = '{
    {2'd0,1'b0,1'b1,2'd3,2'd3,1'b0,1'b0,1'b1,1'b0,2'd0},
    {2'd0,1'b0,1'b1,2'd0,2'd3,1'b0,1'b0,1'b1,1'b0,2'd1},
    {2'd1,1'b0,1'b1,2'd2,2'd3,1'b0,1'b0,1'b1,1'b0,2'd1},
    {2'd2,1'b0,1'b1,2'd0,2'd3,1'b0,1'b0,1'b1,1'b0,2'd0},
    {2'd0,1'b0,1'b1,2'd1,2'd3,1'b0,1'b0,1'b1,1'b0,2'd1},
    {2'd1,1'b0,1'b1,2'd1,2'd3,1'b0,1'b0,1'b1,1'b0,2'd0},
    {2'd1,1'b0,1'b1,2'd3,2'd2,1'b0,1'b0,1'b1,1'b0,2'd1},
    {2'd0,1'b0,1'b1,2'd3,2'd1,1'b0,1'b0,1'b1,1'b0,2'd1},
    {2'd1,1'b1,1'b0,2'd0,2'd3,1'b0,1'b0,1'b1,1'b0,2'd3},
    {2'd1,1'b1,1'b1,2'd0,2'd3,1'b0,1'b0,1'b1,1'b0,2'd1},
    {2'd1,1'b0,1'b0,2'd0,2'd3,1'b0,1'b0,1'b1,1'b0,2'd1},
    {2'd2,1'b0,1'b1,2'd3,2'd3,1'b1,1'b0,1'b1,1'b0,2'd2},
    {2'd0,1'b0,1'b1,2'd3,2'd3,1'b0,1'b1,1'b1,1'b0,2'd2},
    {2'd1,1'b1,1'b1,2'd3,2'd3,1'b1,1'b0,1'b1,1'b0,2'd0},
    {2'd3,1'b0,1'b1,2'd3,2'd3,1'b1,1'b1,1'b1,1'b0,2'd0},
    {2'd1,1'b0,1'b1,2'd0,2'd3,1'b1,1'b0,1'b1,1'b0,2'd1},
    {2'd2,1'b0,1'b1,2'd3,2'd3,1'b0,1'b0,1'b0,1'b0,2'd3},
    {2'd3,1'b0,1'b1,2'd3,2'd3,1'b0,1'b0,1'b1,1'b1,2'd3},
    {2'd2,1'b0,1'b1,2'd3,2'd3,1'b1,1'b0,1'b0,1'b0,2'd2},
    {2'd3,1'b1,1'b1,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,2'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [1:0] idx, input logic [63:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busIdx = idx; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] idx, input logic [63:0] expData,
                         input logic [1:0] expResp, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busIdx = idx;
    #1;
    chk({tag, " data"}, busRdata, expData);
    chk({tag, " resp"}, 64'(busResp), 64'(expResp));
    busSel = 1'b0;
  endtask

  task automatic setDefaults();
    curLvl = 2'd1; secureSt = 1'b0; hasLvl2 = 1'b1; hasLvl3 = 1'b1; lvl3Is64 = 1'b1;
    vecEnField = 2'd3; fpEnField = 2'd3; l2TrapVec = 1'b0; l2TrapFp = 1'b0;
    l3VecEn = 1'b1; l3TrapFp = 1'b0; fpTrapLvl = 2'd0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=done");
    totalCnt++;
    failCnt++;
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    busRead(2'd1, 64'd0, 2'd0, "R1 reg1 after reset");
    busRead(2'd2, 64'd0, 2'd0, "R1 reg2 after reset");
    busRead(2'd3, 64'd0, 2'd0, "R1 reg3 after reset");
    settle();
    chk("R1 effLen after reset", 64'(effLen), 64'd0);
    chk("R6 trapLvl enabled", 64'(trapLvl), 64'd0);

    // R2 R3 R4 R5 R6: trap priority table
    for (int k = 0; k < 20; k++) begin
      logic [1:0] expL;
      @(negedge clk);
      {curLvl, secureSt, lvl3Is64, vecEnField, fpEnField,
       l2TrapVec, l2TrapFp, l3VecEn, l3TrapFp, expL} = TV[k];
      #1;
      chk($sformatf("R2/R3/R4/R5/R6 vector %0d trapLvl", k), 64'(trapLvl), 64'(expL));
    end
    setDefaults();

    // R8: upper bits dropped
    busWrite(2'd1, 64'hFFFF_FFFF_FFFF_FFF7);
    busWrite(2'd2, 64'h5);
    busWrite(2'd3, 64'hA0_0000_0009);
    busRead(2'd1, 64'd7, 2'd0, "R8 reg1 masked");
    busRead(2'd2, 64'd5, 2'd0, "R7 reg2 ok");
    busRead(2'd3, 64'd9, 2'd0, "R8 reg3 masked");

    // R10: clamping per level (regs 7,5,9)
    settle(); chk("R10 cur1", 64'(effLen), 64'd5);
    curLvl = 2'd0; settle(); chk("R10 cur0 uses reg1", 64'(effLen), 64'd5);
    curLvl = 2'd2; settle(); chk("R10 cur2", 64'(effLen), 64'd5);
    curLvl = 2'd3; settle(); chk("R10 cur3 own only", 64'(effLen), 64'd9);
    busWrite(2'd3, 64'h3);
    curLvl = 2'd1; settle(); chk("R10 cur1 clamp by reg3", 64'(effLen), 64'd3);
    curLvl = 2'd2; settle(); chk("R10 cur2 clamp by reg3", 64'(effLen), 64'd3);
    curLvl = 2'd1; hasLvl3 = 1'b0; settle();
    chk("R10 no level3 clamp", 64'(effLen), 64'd5);
    busRead(2'd3, 64'd0, 2'd0, "R9 absent reg3");
    hasLvl2 = 1'b0; settle(); chk("R10 no higher clamps", 64'(effLen), 64'd7);
    curLvl = 2'd2; settle(); chk("R9 absent reg2 as own", 64'(effLen), 64'd0);
    setDefaults();

    // R11: zero length when vector trapped but FP allowed
    vecEnField = 2'd0; settle();
    chk("R11 trapLvl", 64'(trapLvl), 64'd1);
    chk("R11 effLen forced zero", 64'(effLen), 64'd0);
    fpTrapLvl = 2'd1; settle();
    chk("R11 FP trapped keeps length", 64'(effLen), 64'd3);
    fpTrapLvl = 2'd0;

    // R7: responses and blocked access
    busRead(2'd1, 64'd0, 2'd1, "R7 ordinary trap");
    busWrite(2'd1, 64'h2);
    vecEnField = 2'd3; l2TrapVec = 1'b1;
    busRead(2'd1, 64'd0, 2'd2, "R7 trap to level2");
    busWrite(2'd1, 64'h1);
    l2TrapVec = 1'b0; l3VecEn = 1'b0;
    busRead(2'd1, 64'd0, 2'd3, "R7 trap to level3");
    busWrite(2'd1, 64'h4);
    l3VecEn = 1'b1;
    busRead(2'd1, 64'd7, 2'd0, "R7 blocked writes left reg1");

    // R9: absent registers
    hasLvl2 = 1'b0;
    busWrite(2'd2, 64'h9);
    busRead(2'd2, 64'd0, 2'd0, "R9 absent reg2 reads zero");
    l2TrapVec = 1'b1;
    busRead(2'd2, 64'd0, 2'd0, "R9 absent reg2 no trap resp");
    l2TrapVec = 1'b0; hasLvl2 = 1'b1;
    busRead(2'd2, 64'd5, 2'd0, "R9 absent write ignored");
    busWrite(2'd0, 64'hF);
    busRead(2'd0, 64'd0, 2'd0, "R9 index0 reads zero");

    finishRun();
  end
endmodule